// File: doc/BRIEF.md
# Bimodal Direction Predictor with Group-Shared Confidence

This block predicts whether a conditional branch will be taken. A table indexed by the branch address holds one direction bit for each entry. That bit is the prediction. Each aligned group of neighbouring entries shares one strong/weak confidence bit. The direction bit and the shared confidence bit together act like a 2-bit saturating counter: a single wrong outcome cannot reverse a confident prediction. Because the confidence bits are shared, a given number of storage bits covers more branches than a table that keeps a full 2-bit counter for every entry.

The fetch stage presents an address on the prediction port and reads the predicted direction in the same cycle, with no register in the path. Some time later the execute stage reports the resolved branch on the update port. The report carries the address, the actual outcome and the direction that was predicted. The table applies the report on the next rising clock edge. The index is taken from the address bits just above the byte offset. The entry count, the group size, the offset width and the address width are all parameters.

Top module: `bimodal_shared_conf`

## Requirements
- R1: While reset is asserted and after it is released, every direction bit reads as not taken (0) and every confidence bit is weak, so the first misprediction on any entry reverses that entry.
- R2: `pred_taken` is a combinational read of the direction bit selected by `pred_addr`. It follows a change of `pred_addr` within the same cycle, with no clock edge in between.
- R3: The entry index is `addr[OFF_W+IDX_W-1:OFF_W]` (bits 11:2 with the default parameters). Address bits below and above that field do not affect which entry is read or updated.
- R4: A valid update with `upd_taken == upd_pred` sets the confidence of the entry's group to strong and leaves the direction bit unchanged.
- R5: A valid update with `upd_taken != upd_pred`, when the group's confidence is strong, sets that confidence to weak and leaves the direction bit unchanged.
- R6: A valid update with `upd_taken != upd_pred`, when the group's confidence is weak, writes `upd_taken` into the entry's direction bit. The confidence stays weak.
- R7: Entries i and j share one confidence bit exactly when i>>GRP_W equals j>>GRP_W (groups of 4 with the defaults). A correct update on one entry therefore protects its neighbours in the same group from a single misprediction.
- R8: An update changes no confidence bit outside its own group and no direction bit other than its own entry's.
- R9: When a read and an update address the same entry in the same cycle, the read returns the value held before the update. The new value appears after the clock edge.
- R10: While `upd_valid` is low, the table does not change, whatever `upd_addr`, `upd_taken` and `upd_pred` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_addr | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved-branch report is valid this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_pred | input | 1 | Direction that was predicted for this branch |

## Verification
The bench works on confidence sharing between neighbours. It strengthens one entry, then mispredicts a neighbour in the same group and expects that neighbour to hold its direction. It then does the same across a group boundary, where the entry must reverse at once. A design that kept per-entry confidence, or shifted the grouping by one bit, would reverse the neighbour too early or too late.

The bench also checks:
- A read and an update on the same entry in one cycle: a design that forwarded the new value would show the update a cycle early.
- Addresses that alias through their upper and offset bits: a wrong index slice would split one branch over two entries.
- Reports held with `upd_valid` low: the bench follows these with a misprediction and expects a reversal. A design that acted on the ignored report would have strengthened the group, and the direction would hold instead.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    typedef enum logic {
        CONF_WEAK   = 1'b0,
        CONF_STRONG = 1'b1
    } bpc_conf_e;
endpackage

// File: rtl/bpc_addr_index.sv
module bpc_addr_index #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int TOP_B = OFF_W + IDX_W;

    assign idx = addr[TOP_B-1:OFF_W];

    // Bits outside the index field take no part in the lookup.
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:TOP_B], addr[OFF_W-1:0]};
endmodule

// File: rtl/bpc_entry_next.sv
module bpc_entry_next
    import bpc_pkg::*;
(
    input  logic      cur_dir,
    input  bpc_conf_e cur_conf,
    input  logic      taken,
    input  logic      pred,
    output logic      nxt_dir,
    output bpc_conf_e nxt_conf
);
    logic hit;

    always_comb begin
        hit      = (taken == pred);
        nxt_dir  = cur_dir;
        nxt_conf = cur_conf;
        if (hit) begin
            nxt_conf = CONF_STRONG;
        end else if (cur_conf == CONF_STRONG) begin
            nxt_conf = CONF_WEAK;
        end else begin
            nxt_dir  = taken;
            nxt_conf = CONF_WEAK;
        end
    end
endmodule

// File: rtl/bimodal_shared_conf.sv
module bimodal_shared_conf
    import bpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 10,
    parameter int GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic              upd_pred
);
    localparam int N_ENT = 1 << IDX_W;
    localparam int G_W   = IDX_W - GRP_W;
    localparam int N_GRP = 1 << G_W;

    typedef struct packed {
        logic [N_ENT-1:0] dir;
        logic [N_GRP-1:0] conf;
    } tbl_t;

    tbl_t st_d, st_q;

    logic [IDX_W-1:0] p_idx, u_idx;
    logic [G_W-1:0]   u_grp;
    logic             cur_dir, nxt_dir;
    bpc_conf_e        cur_conf, nxt_conf;
    logic [N_ENT-1:0] dir_q;
    logic [N_GRP-1:0] conf_q;

    bpc_addr_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_pidx (
        .addr (pred_addr),
        .idx  (p_idx)
    );

    bpc_addr_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_uidx (
        .addr (upd_addr),
        .idx  (u_idx)
    );

    assign u_grp    = u_idx[IDX_W-1:GRP_W];
    assign dir_q    = st_q.dir;
    assign conf_q   = st_q.conf;
    assign cur_dir  = dir_q[u_idx];
    assign cur_conf = bpc_conf_e'(conf_q[u_grp]);

    bpc_entry_next u_next (
        .cur_dir  (cur_dir),
        .cur_conf (cur_conf),
        .taken    (upd_taken),
        .pred     (upd_pred),
        .nxt_dir  (nxt_dir),
        .nxt_conf (nxt_conf)
    );

    // Read side: old table contents, no forwarding of a same-cycle update.
    assign pred_taken = dir_q[p_idx];

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            st_d.dir[u_idx]  = nxt_dir;
            st_d.conf[u_grp] = (nxt_conf == CONF_STRONG);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
    parameter int IDX_W = 10,
    parameter int GRP_W = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       upd_valid,
    input logic                       upd_taken,
    input logic                       upd_pred,
    input logic [IDX_W-1:0]           u_idx,
    input logic [IDX_W-1:0]           p_idx,
    input logic                       pred_taken,
    input logic [(1<<IDX_W)-1:0]      dir_q,
    input logic [(1<<(IDX_W-GRP_W))-1:0] conf_q
);
    localparam int G_W = IDX_W - GRP_W;

    logic [G_W-1:0] g_u;
    logic           live_q;

    assign g_u = u_idx[IDX_W-1:GRP_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_hit_strong_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_taken == upd_pred)) |=> conf_q[$past(g_u)]);

    assert_strong_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_taken != upd_pred) && conf_q[g_u])
        |=> (!conf_q[$past(g_u)] && (dir_q[$past(u_idx)] == $past(dir_q[u_idx]))));

    assert_weak_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_taken != upd_pred) && !conf_q[g_u])
        |=> ((dir_q[$past(u_idx)] == $past(upd_taken)) && !conf_q[$past(g_u)]));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(upd_valid) && $stable(p_idx)) |-> $stable(pred_taken));
endmodule

bind bimodal_shared_conf bpc_checker #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .upd_pred   (upd_pred),
    .u_idx      (u_idx),
    .p_idx      (p_idx),
    .pred_taken (pred_taken),
    .dir_q      (dir_q),
    .conf_q     (conf_q)
);

// File: tb/bimodal_shared_conf_test.sv
module bimodal_shared_conf_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [9:0] u;
        logic       t;
        logic       p;
        logic [9:0] c;
        logic       e;
    } vec_t;

    // update (index, actual, predicted) then read index c, expect e
    localparam vec_t VECS [NV] = '{
        '{10'd8,    1'b1, 1'b0, 10'd8,    1'b1},  // R6 weak miss flips
        '{10'd8,    1'b1, 1'b1, 10'd8,    1'b1},  // R4 hit -> strong
        '{10'd9,    1'b1, 1'b0, 10'd9,    1'b0},  // R7 neighbour held by shared strong
        '{10'd9,    1'b1, 1'b0, 10'd9,    1'b1},  // R6 now weak, flips
        '{10'd9,    1'b1, 1'b1, 10'd8,    1'b1},  // R4 hit, R8 entry 8 untouched
        '{10'd12,   1'b1, 1'b0, 10'd12,   1'b1},  // R8 next group still weak
        '{10'd10,   1'b1, 1'b0, 10'd10,   1'b0},  // R7 group 2 still strong
        '{10'd8,    1'b0, 1'b1, 10'd8,    1'b0},  // R6 group 2 weak again
        '{10'd7,    1'b0, 1'b0, 10'd7,    1'b0},  // R4 group 1 strong
        '{10'd4,    1'b1, 1'b0, 10'd4,    1'b0},  // R7 entry 4 shares with 7
        '{10'd4,    1'b1, 1'b0, 10'd4,    1'b1},  // R6
        '{10'd1023, 1'b1, 1'b0, 10'd1023, 1'b1}   // R6 top index
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_addr = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic        upd_pred = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bimodal_shared_conf uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_addr  (pred_addr),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_addr   (upd_addr),
        .upd_taken  (upd_taken),
        .upd_pred   (upd_pred)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic [9:0] i, input logic [19:0] hi,
                                       input logic [1:0] off);
        return {hi, i, off};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [31:0] a, input logic exp);
        pred_addr = a;
        #1;
        check(req, pred_taken, exp);
    endtask

    // drive just after a rising edge, committed on the next one
    task automatic upd(input logic [31:0] a, input logic t, input logic p, input logic v);
        upd_valid = v;
        upd_addr  = a;
        upd_taken = t;
        upd_pred  = p;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 during and after reset
        #3;
        read_chk("R1", mk(10'd0, 20'h0, 2'd0), 1'b0);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        read_chk("R1", mk(10'd0,    20'h0, 2'd0), 1'b0);
        read_chk("R1", mk(10'd500,  20'h0, 2'd0), 1'b0);
        read_chk("R1", mk(10'd1023, 20'h0, 2'd0), 1'b0);

        for (int k = 0; k < NV; k++) begin
            upd(mk(VECS[k].u, 20'h0, 2'd0), VECS[k].t, VECS[k].p, 1'b1);
            read_chk($sformatf("vector %0d R4/R5/R6/R7/R8", k),
                     mk(VECS[k].c, 20'h0, 2'd0), VECS[k].e);
        end
        read_chk("R8 entry 5 untouched", mk(10'd5, 20'h0, 2'd0), 1'b0);

        // R3 aliasing through upper and offset bits
        read_chk("R3", mk(10'd1023, 20'hABCDE, 2'd3), 1'b1);
        upd(mk(10'd1023, 20'h12345, 2'd2), 1'b0, 1'b1, 1'b1);
        read_chk("R3", mk(10'd1023, 20'h00000, 2'd0), 1'b0);

        // R2 combinational read, no clock between
        @(negedge clk);
        read_chk("R2", mk(10'd4, 20'h0, 2'd0), 1'b1);
        read_chk("R2", mk(10'd5, 20'h0, 2'd0), 1'b0);

        // R1 second reset clears learned state
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        read_chk("R1 reset clears", mk(10'd8, 20'h0, 2'd0), 1'b0);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        read_chk("R1", mk(10'd4, 20'h0, 2'd0), 1'b0);
        upd(mk(10'd9, 20'h0, 2'd0), 1'b1, 1'b0, 1'b1);
        read_chk("R1 weak after reset", mk(10'd9, 20'h0, 2'd0), 1'b1);

        // R9 same-cycle read and update on entry 0
        pred_addr = mk(10'd0, 20'h0, 2'd0);
        upd_valid = 1'b1;
        upd_addr  = mk(10'd0, 20'h0, 2'd0);
        upd_taken = 1'b1;
        upd_pred  = 1'b0;
        #1;
        check("R9 old value", pred_taken, 1'b0);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        check("R9 new value", pred_taken, 1'b1);

        // R10 ignored hit must not strengthen group 0
        upd(mk(10'd1, 20'h0, 2'd0), 1'b1, 1'b1, 1'b0);
        upd(mk(10'd0, 20'h0, 2'd0), 1'b1, 1'b1, 1'b0);
        read_chk("R10 dir held", mk(10'd0, 20'h0, 2'd0), 1'b1);
        upd(mk(10'd0, 20'h0, 2'd0), 1'b0, 1'b1, 1'b1);
        read_chk("R10 conf held weak", mk(10'd0, 20'h0, 2'd0), 1'b0);

        // R5 strong miss holds, second miss reverses
        upd(mk(10'd2, 20'h0, 2'd0), 1'b0, 1'b0, 1'b1);
        upd(mk(10'd0, 20'h0, 2'd0), 1'b1, 1'b0, 1'b1);
        read_chk("R5 held", mk(10'd0, 20'h0, 2'd0), 1'b0);
        upd(mk(10'd0, 20'h0, 2'd0), 1'b1, 1'b0, 1'b1);
        read_chk("R6 after R5", mk(10'd0, 20'h0, 2'd0), 1'b1);

        finish_run();
    end
endmodule